// File: doc/BRIEF.md
# Trace Port Beat Serializer

This block turns one trace message into a stream of narrow port beats. A message is a 6-bit kind code followed by up to four fields. Each field has a value of up to 32 bits, a bit length, and a flag that marks it as variable-length. Every beat carries 6 data bits and a 2-bit frame code. The frame code marks the opening of a message, the close of a variable-length field and the close of the message. Each field starts on a fresh beat, is sent low bits first, and has the unused top bits of its last beat forced to zero.

A message is offered on a valid/ready handshake. `msg_ready` is high while the serializer is idle, and a message is taken on a clock edge where `msg_valid` and `msg_ready` are both high. After that `msg_ready` stays low until the cycle in which the closing beat is on the port. While `msg_ready` is low, the message inputs and `msg_valid` have no effect, so a producer may hold or change them freely. The port has two beat lanes. In single-rate mode only lane A carries beats. In double-rate mode lane A holds the first beat of each clock and lane B the second, and a pad cell outside this block drives them on the two clock edges. The rate is sampled when a message is taken.

Top module: `trace_beat_serializer`

## Requirements
- R1: After reset, and in every cycle after the first cycle in which `msg_ready` is back high, both lanes show frame code 11 with data 0, and `msg_ready` is 1.
- R2: The first beat of a message carries the kind code on lane A, with frame code 00 when the message has at least one field.
- R3: Every beat that does not close a field shows frame code 00, and so does the last beat of a fixed-length field that is not the final field. Frame code 10 never appears.
- R4: The last beat of a variable-length field (flag bit 1) that is not the final field shows frame code 01.
- R5: The last beat of the message shows frame code 11: the last beat of the final field, or the kind beat when the field count is 0.
- R6: Field i (i = 0..3) takes bits `[32*i +: 32]` of the value bus, bits `[6*i +: 6]` of the length bus and bit i of the flag bus. It spans ceil(len/6) beats, or one beat when len is 0. Beat b carries value bits 6*b up to 6*b+5, with the lowest bit in data bit 0. Fields go out in index order after the kind beat. A field count above 4 is treated as 4.
- R7: Data bits at positions at or above a field's length are sent as 0, whatever the value bus holds there.
- R8: In single-rate mode (`ddr_en` = 0 when the message is taken), one beat appears on lane A per cycle and lane B stays at frame 11 with data 0.
- R9: In double-rate mode, beats 2k and 2k+1 appear together on lanes A and B. When the count is odd, lane B is idle (frame 11, data 0) in the closing cycle. Changing `ddr_en` during a message has no effect on it.
- R10: `msg_ready` falls in the cycle after a message is taken and rises in the cycle in which the closing beat is shown. While it is low, `msg_valid` and all message inputs are ignored.
- R11: The first beat appears in the second cycle after the accepting edge, and the beats follow with no idle cycle until the message closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ddr_en | input | 1 | 1 selects two beats per clock, sampled when a message is taken |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | The serializer takes a message on this edge when valid |
| msg_kind | input | 6 | Kind code sent in the first beat |
| msg_field_count | input | 3 | Number of fields, 0 to 4 |
| msg_field_val | input | 128 | Four 32-bit field values, field 0 lowest |
| msg_field_len | input | 24 | Four 6-bit field lengths in bits |
| msg_field_var | input | 4 | Per field: 1 for a variable-length field |
| tp_data_a | output | 6 | Lane A beat data |
| tp_frame_a | output | 2 | Lane A frame code |
| tp_data_b | output | 6 | Lane B beat data (double-rate second beat) |
| tp_frame_b | output | 2 | Lane B frame code |

## Verification
The assertions assume that the producer keeps the handshake inputs stable only at sampled edges and never expects a message to be taken while `msg_ready` is low. They also rely on the rate being held in a register that changes only at an accepting edge, so lane B may be checked against it. The stimulus keeps field lengths within 0 to 32 and field counts within 0 to 7. During busy periods it drives random values onto every message input, pulses `msg_valid` and flips `ddr_en`, which tests that these are ignored rather than assumed quiet. It drops `msg_valid` in the cycle `msg_ready` returns, so no message is taken by accident.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  // Frame codes on the sideband; 2'b10 is never driven.
  typedef enum logic [1:0] {
    FRM_BODY      = 2'b00,
    FRM_FIELD_END = 2'b01,
    FRM_IDLE_EOM  = 2'b11
  } frame_code_e;

endpackage

// File: rtl/tbs_field_sizer.sv
module tbs_field_sizer #(
  parameter int BEAT_W = 6,
  parameter int LEN_W  = 6,
  parameter int BI_W   = 3
) (
  input  logic [LEN_W-1:0] len,
  output logic [BI_W-1:0]  nbeats
);

  logic [LEN_W:0] padded;
  logic [LEN_W:0] quot;

  always_comb begin
    padded = {1'b0, len} + (LEN_W+1)'(BEAT_W - 1);
    quot   = padded / (LEN_W+1)'(BEAT_W);
    if (len == '0) nbeats = BI_W'(1);
    else           nbeats = BI_W'(quot);
  end

endmodule

// File: rtl/tbs_beat_slicer.sv
module tbs_beat_slicer #(
  parameter int BEAT_W  = 6,
  parameter int FIELD_W = 32,
  parameter int LEN_W   = 6,
  parameter int BI_W    = 3
) (
  input  logic [FIELD_W-1:0] value,
  input  logic [LEN_W-1:0]   len,
  input  logic [BI_W-1:0]    beat_idx,
  output logic [BEAT_W-1:0]  beat
);

  localparam int POS_W = LEN_W + BI_W + 1;

  logic [POS_W-1:0]   base;
  logic [FIELD_W-1:0] shifted;

  always_comb begin
    base    = POS_W'(beat_idx) * POS_W'(BEAT_W);
    shifted = value >> base;
    for (int k = 0; k < BEAT_W; k++) begin
      // keep a bit only while its field position is below the length
      beat[k] = shifted[k] & ((base + POS_W'(k)) < POS_W'(len));
    end
  end

endmodule

// File: rtl/tbs_beat_source.sv
module tbs_beat_source
  import tbs_pkg::*;
#(
  parameter int BEAT_W     = 6,
  parameter int FIELD_W    = 32,
  parameter int MAX_FIELDS = 4,
  parameter int LEN_W      = 6,
  parameter int BI_W       = 3,
  parameter int FIDX_W     = 3,
  parameter int SEL_W      = 2
) (
  input  logic [FIDX_W-1:0]  cur_fld,
  input  logic [BI_W-1:0]    cur_bi,
  input  logic [BEAT_W-1:0]  kind,
  input  logic [FIDX_W-1:0]  nfields,
  input  logic [FIELD_W-1:0] vals   [MAX_FIELDS],
  input  logic [LEN_W-1:0]   lens   [MAX_FIELDS],
  input  logic [BI_W-1:0]    nbeats [MAX_FIELDS],
  input  logic [MAX_FIELDS-1:0] var_flags,
  output logic [BEAT_W-1:0]  data,
  output logic [1:0]         frame,
  output logic               is_last,
  output logic [FIDX_W-1:0]  nxt_fld,
  output logic [BI_W-1:0]    nxt_bi
);

  logic [SEL_W-1:0]  sel;
  logic [BEAT_W-1:0] slice;
  logic              on_kind;
  logic              field_end;

  assign on_kind = (cur_fld == '0);
  assign sel     = SEL_W'(cur_fld - 1'b1);

  tbs_beat_slicer #(
    .BEAT_W (BEAT_W),
    .FIELD_W(FIELD_W),
    .LEN_W  (LEN_W),
    .BI_W   (BI_W)
  ) slicer_i (
    .value   (vals[sel]),
    .len     (lens[sel]),
    .beat_idx(cur_bi),
    .beat    (slice)
  );

  always_comb begin
    if (on_kind) begin
      data      = kind;
      field_end = 1'b1;
      is_last   = (nfields == '0);
    end else begin
      data      = slice;
      field_end = (cur_bi == BI_W'(nbeats[sel] - 1'b1));
      is_last   = field_end && (cur_fld == nfields);
    end

    if (is_last)
      frame = FRM_IDLE_EOM;
    else if (field_end && !on_kind && var_flags[sel])
      frame = FRM_FIELD_END;
    else
      frame = FRM_BODY;

    if (field_end) begin
      nxt_fld = cur_fld + 1'b1;
      nxt_bi  = '0;
    end else begin
      nxt_fld = cur_fld;
      nxt_bi  = cur_bi + 1'b1;
    end
  end

endmodule

// File: rtl/trace_beat_serializer.sv
module trace_beat_serializer
  import tbs_pkg::*;
#(
  parameter int BEAT_W     = 6,
  parameter int FIELD_W    = 32,
  parameter int MAX_FIELDS = 4,
  parameter int LEN_W      = $clog2(FIELD_W + 1),
  parameter int FIDX_W     = $clog2(MAX_FIELDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ddr_en,
  input  logic                          msg_valid,
  output logic                          msg_ready,
  input  logic [BEAT_W-1:0]             msg_kind,
  input  logic [FIDX_W-1:0]             msg_field_count,
  input  logic [MAX_FIELDS*FIELD_W-1:0] msg_field_val,
  input  logic [MAX_FIELDS*LEN_W-1:0]   msg_field_len,
  input  logic [MAX_FIELDS-1:0]         msg_field_var,
  output logic [BEAT_W-1:0]             tp_data_a,
  output logic [1:0]                    tp_frame_a,
  output logic [BEAT_W-1:0]             tp_data_b,
  output logic [1:0]                    tp_frame_b
);

  localparam int MAX_BEATS = (FIELD_W + BEAT_W - 1) / BEAT_W;
  localparam int BI_W      = $clog2(MAX_BEATS + 1);
  localparam int SEL_W     = (MAX_FIELDS > 1) ? $clog2(MAX_FIELDS) : 1;

  // latched message
  logic                  busy_q;
  logic                  ddr_q;
  logic [BEAT_W-1:0]     kind_q;
  logic [FIDX_W-1:0]     nf_q;
  logic [FIELD_W-1:0]    val_q   [MAX_FIELDS];
  logic [LEN_W-1:0]      len_q   [MAX_FIELDS];
  logic [BI_W-1:0]       nbeats  [MAX_FIELDS];
  logic [MAX_FIELDS-1:0] var_q;

  // stream cursor: field 0 is the kind beat, 1..N are the fields
  logic [FIDX_W-1:0] cur_fld_q;
  logic [BI_W-1:0]   cur_bi_q;

  // output lanes
  logic [BEAT_W-1:0] data_a_q, data_b_q;
  logic [1:0]        frame_a_q, frame_b_q;

  logic              accept;
  logic [FIDX_W-1:0] count_clamped;

  assign msg_ready = !busy_q;
  assign accept    = msg_valid && msg_ready;
  assign count_clamped = (msg_field_count > FIDX_W'(MAX_FIELDS)) ?
                         FIDX_W'(MAX_FIELDS) : msg_field_count;

  generate
    for (genvar f = 0; f < MAX_FIELDS; f++) begin : g_size
      tbs_field_sizer #(
        .BEAT_W(BEAT_W),
        .LEN_W (LEN_W),
        .BI_W  (BI_W)
      ) sizer_i (
        .len   (len_q[f]),
        .nbeats(nbeats[f])
      );
    end
  endgenerate

  // lane A works from the cursor, lane B from lane A's successor
  logic [BEAT_W-1:0] a_data, b_data;
  logic [1:0]        a_frame, b_frame;
  logic              a_last, b_last;
  logic [FIDX_W-1:0] a_nxt_fld, b_nxt_fld;
  logic [BI_W-1:0]   a_nxt_bi, b_nxt_bi;
  logic              b_has;

  tbs_beat_source #(
    .BEAT_W(BEAT_W), .FIELD_W(FIELD_W), .MAX_FIELDS(MAX_FIELDS),
    .LEN_W(LEN_W), .BI_W(BI_W), .FIDX_W(FIDX_W), .SEL_W(SEL_W)
  ) lane_a_src_i (
    .cur_fld  (cur_fld_q),
    .cur_bi   (cur_bi_q),
    .kind     (kind_q),
    .nfields  (nf_q),
    .vals     (val_q),
    .lens     (len_q),
    .nbeats   (nbeats),
    .var_flags(var_q),
    .data     (a_data),
    .frame    (a_frame),
    .is_last  (a_last),
    .nxt_fld  (a_nxt_fld),
    .nxt_bi   (a_nxt_bi)
  );

  tbs_beat_source #(
    .BEAT_W(BEAT_W), .FIELD_W(FIELD_W), .MAX_FIELDS(MAX_FIELDS),
    .LEN_W(LEN_W), .BI_W(BI_W), .FIDX_W(FIDX_W), .SEL_W(SEL_W)
  ) lane_b_src_i (
    .cur_fld  (a_nxt_fld),
    .cur_bi   (a_nxt_bi),
    .kind     (kind_q),
    .nfields  (nf_q),
    .vals     (val_q),
    .lens     (len_q),
    .nbeats   (nbeats),
    .var_flags(var_q),
    .data     (b_data),
    .frame    (b_frame),
    .is_last  (b_last),
    .nxt_fld  (b_nxt_fld),
    .nxt_bi   (b_nxt_bi)
  );

  assign b_has = busy_q && ddr_q && !a_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      ddr_q     <= 1'b0;
      kind_q    <= '0;
      nf_q      <= '0;
      var_q     <= '0;
      cur_fld_q <= '0;
      cur_bi_q  <= '0;
      for (int i = 0; i < MAX_FIELDS; i++) begin
        val_q[i] <= '0;
        len_q[i] <= '0;
      end
      data_a_q  <= '0;
      data_b_q  <= '0;
      frame_a_q <= FRM_IDLE_EOM;
      frame_b_q <= FRM_IDLE_EOM;
    end else begin
      if (accept) begin
        busy_q    <= 1'b1;
        ddr_q     <= ddr_en;
        kind_q    <= msg_kind;
        nf_q      <= count_clamped;
        var_q     <= msg_field_var;
        cur_fld_q <= '0;
        cur_bi_q  <= '0;
        for (int i = 0; i < MAX_FIELDS; i++) begin
          val_q[i] <= msg_field_val[i*FIELD_W +: FIELD_W];
          len_q[i] <= msg_field_len[i*LEN_W +: LEN_W];
        end
      end else if (busy_q) begin
        cur_fld_q <= ddr_q ? b_nxt_fld : a_nxt_fld;
        cur_bi_q  <= ddr_q ? b_nxt_bi  : a_nxt_bi;
        if (a_last || (b_has && b_last)) busy_q <= 1'b0;
      end

      data_a_q  <= busy_q ? a_data  : '0;
      frame_a_q <= busy_q ? a_frame : FRM_IDLE_EOM;
      data_b_q  <= b_has  ? b_data  : '0;
      frame_b_q <= b_has  ? b_frame : FRM_IDLE_EOM;
    end
  end

  assign tp_data_a  = data_a_q;
  assign tp_frame_a = frame_a_q;
  assign tp_data_b  = data_b_q;
  assign tp_frame_b = frame_b_q;

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int BEAT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic              ddr_q,
  input logic [BEAT_W-1:0] data_a,
  input logic [1:0]        frame_a,
  input logic [BEAT_W-1:0] data_b,
  input logic [1:0]        frame_b
);

  a_r1_idle_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && $past(msg_ready)) |->
      (frame_a == 2'b11 && data_a == '0 && frame_b == 2'b11 && data_b == '0));

  a_r3_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_a != 2'b10) && (frame_b != 2'b10));

  a_r5_eom_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_ready) |-> (frame_a == 2'b11 || frame_b == 2'b11));

  a_r8_lane_b_idle_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_q |-> (frame_b == 2'b11 && data_b == '0));

  a_r9_lane_b_after_eom: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_a == 2'b11) |-> (frame_b == 2'b11 && data_b == '0));

  a_r10_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_ready);

  a_r11_stream_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_ready && $past(!msg_ready)) |-> (frame_a != 2'b11));

endmodule

bind trace_beat_serializer tbs_checker #(.BEAT_W(BEAT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .msg_valid(msg_valid),
  .msg_ready(msg_ready),
  .ddr_q    (ddr_q),
  .data_a   (tp_data_a),
  .frame_a  (tp_frame_a),
  .data_b   (tp_data_b),
  .frame_b  (tp_frame_b)
);

// File: tb/trace_beat_serializer_tb_top.sv
`timescale 1ns/1ps
module trace_beat_serializer_tb_top;

  localparam int BW = 6;
  localparam int FW = 32;
  localparam int NF = 4;
  localparam int LW = 6;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ddr_en = 1'b0;
  logic msg_valid = 1'b0;
  logic msg_ready;
  logic [BW-1:0]    msg_kind = '0;
  logic [CW-1:0]    msg_field_count = '0;
  logic [NF*FW-1:0] msg_field_val = '0;
  logic [NF*LW-1:0] msg_field_len = '0;
  logic [NF-1:0]    msg_field_var = '0;
  logic [BW-1:0] tp_data_a, tp_data_b;
  logic [1:0]    tp_frame_a, tp_frame_b;

  always #4 clk = ~clk;

  trace_beat_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .ddr_en(ddr_en),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_field_count(msg_field_count),
    .msg_field_val(msg_field_val), .msg_field_len(msg_field_len),
    .msg_field_var(msg_field_var),
    .tp_data_a(tp_data_a), .tp_frame_a(tp_frame_a),
    .tp_data_b(tp_data_b), .tp_frame_b(tp_frame_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  // message under test and its expected beats
  logic [BW-1:0] m_kind;
  int            m_count;
  logic [FW-1:0] m_val [NF];
  int            m_len [NF];
  logic [NF-1:0] m_var;
  logic [BW-1:0] e_data [64];
  logic [1:0]    e_frm  [64];
  int            e_n;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build();
    int nf;
    nf = (m_count > NF) ? NF : m_count;
    e_n = 0;
    e_data[0] = m_kind;
    e_frm[0]  = (nf == 0) ? 2'b11 : 2'b00;
    e_n = 1;
    for (int f = 0; f < nf; f++) begin
      int nb;
      nb = (m_len[f] == 0) ? 1 : (m_len[f] + BW - 1) / BW;
      for (int b = 0; b < nb; b++) begin
        logic [BW-1:0] d;
        for (int k = 0; k < BW; k++) begin
          int p;
          p = b * BW + k;
          d[k] = (p < m_len[f] && p < FW) ? m_val[f][p] : 1'b0;
        end
        e_data[e_n] = d;
        if (b != nb - 1)      e_frm[e_n] = 2'b00;
        else if (f == nf - 1) e_frm[e_n] = 2'b11;
        else                  e_frm[e_n] = m_var[f] ? 2'b01 : 2'b00;
        e_n++;
      end
    end
  endtask

  task automatic drive_msg();
    msg_kind        = m_kind;
    msg_field_count = CW'(m_count);
    msg_field_var   = m_var;
    for (int f = 0; f < NF; f++) begin
      msg_field_val[f*FW +: FW] = m_val[f];
      msg_field_len[f*LW +: LW] = LW'(m_len[f]);
    end
  endtask

  task automatic drive_garbage();
    msg_kind        = BW'(rnd());
    msg_field_count = CW'(rnd());
    msg_field_var   = NF'(rnd());
    for (int f = 0; f < NF; f++) begin
      msg_field_val[f*FW +: FW] = rnd();
      msg_field_len[f*LW +: LW] = LW'(rnd());
    end
  endtask

  function automatic string frm_tag(input int i);
    if (i == 0)             return "R2";
    if (e_frm[i] == 2'b11)  return "R5";
    if (e_frm[i] == 2'b01)  return "R4";
    return "R3";
  endfunction

  task automatic run_msg(input bit ddr, input bit scramble);
    int cycles;
    build();
    @(negedge clk);
    chk(msg_ready == 1'b1, "R10 ready before offer", msg_ready, 1);
    drive_msg();
    ddr_en = ddr;
    msg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(msg_ready == 1'b0, "R10 ready after accept", msg_ready, 0);
    chk(tp_frame_a == 2'b11, "R11 no beat before latency", tp_frame_a, 3);
    if (scramble) begin
      msg_valid = 1'b1; drive_garbage(); ddr_en = ~ddr;
    end else begin
      msg_valid = 1'b0;
    end
    cycles = ddr ? (e_n + 1) / 2 : e_n;
    for (int c = 0; c < cycles; c++) begin
      int ia;
      bit last;
      @(posedge clk);
      @(negedge clk);
      ia = ddr ? 2 * c : c;
      last = (c == cycles - 1);
      chk(tp_data_a == e_data[ia], "R6/R7/R11 lane A data", tp_data_a, e_data[ia]);
      chk(tp_frame_a == e_frm[ia], frm_tag(ia), tp_frame_a, e_frm[ia]);
      if (ddr && ia + 1 < e_n) begin
        chk(tp_data_b == e_data[ia+1], "R9 lane B data", tp_data_b, e_data[ia+1]);
        chk(tp_frame_b == e_frm[ia+1], "R9 lane B frame", tp_frame_b, e_frm[ia+1]);
      end else begin
        chk(tp_frame_b == 2'b11 && tp_data_b == '0, ddr ? "R9 lane B idle" : "R8 lane B idle",
            {tp_frame_b, tp_data_b}, {2'b11, 6'h00});
      end
      chk(msg_ready == last, "R10 ready timing", msg_ready, last);
      if (scramble && !last) begin
        msg_valid = 1'b1; drive_garbage(); ddr_en = ~ddr;
      end else begin
        msg_valid = 1'b0; ddr_en = ddr;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tp_frame_a == 2'b11 && tp_data_a == '0 && tp_frame_b == 2'b11 && tp_data_b == '0,
        "R1 idle after message", {tp_frame_a, tp_data_a, tp_frame_b, tp_data_b}, 16'hC0C0);
    chk(msg_ready == 1'b1, "R1 ready idle", msg_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      m_val[f] = '0;
      m_len[f] = 0;
    end
    m_var = '0;
    m_kind = '0;
    m_count = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(msg_ready == 1'b1, "R1 ready in reset", msg_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tp_frame_a == 2'b11 && tp_data_a == '0 && tp_frame_b == 2'b11 && tp_data_b == '0,
        "R1 reset idle", {tp_frame_a, tp_data_a, tp_frame_b, tp_data_b}, 16'hC0C0);

    // R5: messages with no field at all
    for (int d = 0; d < 2; d++) begin
      m_kind = 6'h2A; m_count = 0;
      run_msg(d[0], 1'b0);
    end

    // R6/R7: one field, every length, garbage above the length
    for (int d = 0; d < 2; d++)
      for (int v = 0; v < 2; v++)
        for (int len = 0; len <= FW; len++) begin
          m_kind = BW'(rnd());
          m_count = 1;
          m_val[0] = rnd() | 32'h8000_0001;
          m_len[0] = len;
          m_var = NF'(v);
          run_msg(d[0], 1'b0);
        end

    // R3/R4/R9/R10: several fields, every flag mix, busy-time noise
    for (int d = 0; d < 2; d++)
      for (int n = 1; n <= NF; n++)
        for (int vm = 0; vm < (1 << NF); vm++) begin
          m_kind = BW'(rnd());
          m_count = n;
          m_var = NF'(vm);
          for (int f = 0; f < NF; f++) begin
            m_val[f] = rnd();
            m_len[f] = (vm * 7 + f * 11 + n) % (FW + 1);
          end
          run_msg(d[0], vm[0]);
        end

    // R6: counts above four act as four
    for (int c = NF + 1; c < 8; c++) begin
      m_count = c;
      m_var = 4'b0101;
      for (int f = 0; f < NF; f++) begin
        m_val[f] = rnd();
        m_len[f] = 6 + f * 7;
      end
      run_msg(c[0], 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule